// File: doc/BRIEF.md
# Vector Operand Register Store with Scalar Broadcast

This block is the operand storage of a near-memory processing element that sits between an even and an odd memory bank. It keeps two halves of a vector register file, each entry one 256-bit burst made of 16 half-precision lanes. The first half (A) holds the input vector. The second half (B) collects accumulation results. Beside them sit two small scalar files: one holds additive constants and one holds multiplicative factors. Scalar entries are stored as 16-bit values and are copied into all 16 lanes whenever they are read as an operand.

A single move port carries all data transfers. It covers a fill from either bank into any register, a copy between vector halves, and a write-out of a vector register to either bank. Each move can clamp negative lanes to zero on the way. Two combinational operand ports feed a 16-lane arithmetic datapath, which lies outside this block. A plain strobe-and-data bank port stands in for the memory banks.

Top module: `pe_operand_store`

## Requirements
- R1: While rst_ni is low, and after it rises, every vector and scalar entry reads as zero on both operand ports.
- R2: A move with source code 2 (even bank) or 3 (odd bank) asserts bank_rd_o in the same cycle. bank_rd_odd_o is high only for code 3. The next cycle, the register selected by the destination code holds bank_rdata_i.
- R3: Destination code 0 writes vector half A and code 1 writes vector half B. A write to one half never changes the entry with the same index in the other half.
- R4: Operand select codes are 0 = vector A, 1 = vector B, 2 = additive scalar, 3 = multiplicative scalar. A scalar operand appears in all 16 lanes of the 256-bit operand output.
- R5: Destination code 2 writes the additive scalar file and code 3 writes the multiplicative scalar file, each taking lane 0 (bits 15:0) of the moved vector. The two scalar files are independent.
- R6: With mv_relu_i set, every 16-bit lane whose bit 15 is set, including 0x8000, becomes 0x0000 at the destination. Other lanes pass unchanged. With mv_relu_i clear, all lanes pass unchanged.
- R7: A move with destination code 4 (even bank) or 5 (odd bank) asserts bank_wr_o in the same cycle, with bank_wr_odd_o high only for code 5. bank_wdata_o carries the selected source after the optional clamp. No register changes.
- R8: When an operand port reads the entry being written in the same cycle, it returns the old value. The new value shows from the next cycle.
- R9: The two operand ports select file and index independently of each other and of the move port.
- R10: With mv_valid_i low, or with destination code 6 or 7, no register changes. With mv_valid_i low, both bank strobes stay low.
- R11: Source code 0 or 1 reads entry mv_src_idx_i of vector half A or B, so a move can copy between or within the vector halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mv_valid_i | input | 1 | Move request this cycle |
| mv_src_i | input | 2 | Move source: 0 vec A, 1 vec B, 2 even bank, 3 odd bank |
| mv_src_idx_i | input | 3 | Source register index |
| mv_dst_i | input | 3 | Move destination: 0 vec A, 1 vec B, 2 add scalar, 3 mul scalar, 4 even bank, 5 odd bank |
| mv_dst_idx_i | input | 3 | Destination register index |
| mv_relu_i | input | 1 | Clamp negative lanes to zero |
| bank_rdata_i | input | 256 | Bank read data |
| bank_rd_o | output | 1 | Bank read strobe |
| bank_rd_odd_o | output | 1 | Read targets the odd bank |
| bank_wr_o | output | 1 | Bank write strobe |
| bank_wr_odd_o | output | 1 | Write targets the odd bank |
| bank_wdata_o | output | 256 | Bank write data |
| opd0_sel_i | input | 2 | Operand 0 file select |
| opd0_idx_i | input | 3 | Operand 0 index |
| opd0_data_o | output | 256 | Operand 0 vector |
| opd1_sel_i | input | 2 | Operand 1 file select |
| opd1_idx_i | input | 3 | Operand 1 index |
| opd1_data_o | output | 256 | Operand 1 vector |

## Verification
Some properties are checked on every cycle. A scalar operand always shows identical lanes. A clamped bank write never carries a set sign bit. An idle cycle raises no bank strobe and leaves every held operand unchanged, and so does a cycle that writes to a bank. Other behaviour needs the bench's scenarios and its per-cycle model, because it depends on values stored earlier. This covers correct routing to the right file and index, independence of the two vector halves and the two scalar files, the old value returned on a same-cycle read and write, and the exact clamping of lanes such as 0x8000 and 0x7FFF.

// File: rtl/pe_rf_pkg.sv
package pe_rf_pkg;
  typedef enum logic [1:0] {
    SRC_VEC_A     = 2'd0,
    SRC_VEC_B     = 2'd1,
    SRC_BANK_EVEN = 2'd2,
    SRC_BANK_ODD  = 2'd3
  } mv_src_e;

  typedef enum logic [2:0] {
    DST_VEC_A     = 3'd0,
    DST_VEC_B     = 3'd1,
    DST_SCL_ADD   = 3'd2,
    DST_SCL_MUL   = 3'd3,
    DST_BANK_EVEN = 3'd4,
    DST_BANK_ODD  = 3'd5
  } mv_dst_e;

  typedef enum logic [1:0] {
    OPD_VEC_A   = 2'd0,
    OPD_VEC_B   = 2'd1,
    OPD_SCL_ADD = 2'd2,
    OPD_SCL_MUL = 2'd3
  } opd_sel_e;
endpackage

// File: rtl/pe_relu_lanes.sv
module pe_relu_lanes #(
  parameter int LANES  = 16,
  parameter int LANE_W = 16
) (
  input  logic                    en_i,
  input  logic [LANES*LANE_W-1:0] vec_i,
  output logic [LANES*LANE_W-1:0] vec_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic neg;
    assign neg = en_i & vec_i[l*LANE_W + LANE_W-1];
    assign vec_o[l*LANE_W +: LANE_W] = neg ? '0 : vec_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/pe_vec_rf.sv
module pe_vec_rf #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 256,
  parameter int NRD   = 2
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   we_i,
  input  logic [$clog2(DEPTH)-1:0]               waddr_i,
  input  logic [WIDTH-1:0]                       wdata_i,
  input  logic [NRD-1:0][$clog2(DEPTH)-1:0]      raddr_i,
  output logic [NRD-1:0][WIDTH-1:0]              rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // reads see the registered value: same-cycle write is not bypassed
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end
endmodule

// File: rtl/pe_opd_mux.sv
module pe_opd_mux
  import pe_rf_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = 16
) (
  input  logic [1:0]              sel_i,
  input  logic [LANES*LANE_W-1:0] vec_a_i,
  input  logic [LANES*LANE_W-1:0] vec_b_i,
  input  logic [LANE_W-1:0]       scl_add_i,
  input  logic [LANE_W-1:0]       scl_mul_i,
  output logic [LANES*LANE_W-1:0] data_o
);
  always_comb begin
    unique case (sel_i)
      OPD_VEC_A:   data_o = vec_a_i;
      OPD_VEC_B:   data_o = vec_b_i;
      OPD_SCL_ADD: data_o = {LANES{scl_add_i}};
      default:     data_o = {LANES{scl_mul_i}};
    endcase
  end
endmodule

// File: rtl/pe_operand_store.sv
module pe_operand_store
  import pe_rf_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = 16,
  parameter int DEPTH  = 8,
  localparam int VEC_W = LANES * LANE_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mv_valid_i,
  input  logic [1:0]       mv_src_i,
  input  logic [IDX_W-1:0] mv_src_idx_i,
  input  logic [2:0]       mv_dst_i,
  input  logic [IDX_W-1:0] mv_dst_idx_i,
  input  logic             mv_relu_i,
  input  logic [VEC_W-1:0] bank_rdata_i,
  output logic             bank_rd_o,
  output logic             bank_rd_odd_o,
  output logic             bank_wr_o,
  output logic             bank_wr_odd_o,
  output logic [VEC_W-1:0] bank_wdata_o,
  input  logic [1:0]       opd0_sel_i,
  input  logic [IDX_W-1:0] opd0_idx_i,
  output logic [VEC_W-1:0] opd0_data_o,
  input  logic [1:0]       opd1_sel_i,
  input  logic [IDX_W-1:0] opd1_idx_i,
  output logic [VEC_W-1:0] opd1_data_o
);
  localparam int VEC_RD = 3;  // opd0, opd1, move source
  localparam int SCL_RD = 2;  // opd0, opd1

  logic [VEC_RD-1:0][VEC_W-1:0]  vec_rd [2];
  logic [SCL_RD-1:0][LANE_W-1:0] scl_rd [2];
  logic [VEC_RD-1:0][IDX_W-1:0]  vec_raddr;
  logic [SCL_RD-1:0][IDX_W-1:0]  scl_raddr;
  logic [VEC_W-1:0]              src_vec;
  logic [VEC_W-1:0]              mv_vec;
  logic                          dst_bank;

  assign vec_raddr = {mv_src_idx_i, opd1_idx_i, opd0_idx_i};
  assign scl_raddr = {opd1_idx_i, opd0_idx_i};

  always_comb begin
    unique case (mv_src_i)
      SRC_VEC_A: src_vec = vec_rd[0][2];
      SRC_VEC_B: src_vec = vec_rd[1][2];
      default:   src_vec = bank_rdata_i;
    endcase
  end

  pe_relu_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_relu (
    .en_i  (mv_relu_i),
    .vec_i (src_vec),
    .vec_o (mv_vec)
  );

  for (genvar h = 0; h < 2; h++) begin : g_vec
    logic we;
    assign we = mv_valid_i && (mv_dst_i == 3'(h));
    pe_vec_rf #(.DEPTH(DEPTH), .WIDTH(VEC_W), .NRD(VEC_RD)) u_rf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .waddr_i (mv_dst_idx_i),
      .wdata_i (mv_vec),
      .raddr_i (vec_raddr),
      .rdata_o (vec_rd[h])
    );
  end

  for (genvar h = 0; h < 2; h++) begin : g_scl
    logic we;
    assign we = mv_valid_i && (mv_dst_i == 3'(DST_SCL_ADD) + 3'(h));
    pe_vec_rf #(.DEPTH(DEPTH), .WIDTH(LANE_W), .NRD(SCL_RD)) u_rf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .waddr_i (mv_dst_idx_i),
      .wdata_i (mv_vec[LANE_W-1:0]),
      .raddr_i (scl_raddr),
      .rdata_o (scl_rd[h])
    );
  end

  logic [1:0]       opd_sel  [2];
  logic [VEC_W-1:0] opd_data [2];
  assign opd_sel[0] = opd0_sel_i;
  assign opd_sel[1] = opd1_sel_i;

  for (genvar p = 0; p < 2; p++) begin : g_opd
    pe_opd_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_mux (
      .sel_i     (opd_sel[p]),
      .vec_a_i   (vec_rd[0][p]),
      .vec_b_i   (vec_rd[1][p]),
      .scl_add_i (scl_rd[0][p]),
      .scl_mul_i (scl_rd[1][p]),
      .data_o    (opd_data[p])
    );
  end

  assign opd0_data_o = opd_data[0];
  assign opd1_data_o = opd_data[1];

  assign dst_bank      = (mv_dst_i == DST_BANK_EVEN) || (mv_dst_i == DST_BANK_ODD);
  assign bank_rd_o     = mv_valid_i & mv_src_i[1];
  assign bank_rd_odd_o = bank_rd_o & mv_src_i[0];
  assign bank_wr_o     = mv_valid_i & dst_bank;
  assign bank_wr_odd_o = bank_wr_o & mv_dst_i[0];
  assign bank_wdata_o  = bank_wr_o ? mv_vec : '0;
endmodule

// File: rtl/pe_operand_store_chk.sv
module pe_operand_store_chk #(
  parameter int LANES  = 16,
  parameter int LANE_W = 16,
  parameter int DEPTH  = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       mv_valid_i,
  input logic                       mv_relu_i,
  input logic                       bank_rd_o,
  input logic                       bank_wr_o,
  input logic [LANES*LANE_W-1:0]    bank_wdata_o,
  input logic [1:0]                 opd0_sel_i,
  input logic [$clog2(DEPTH)-1:0]   opd0_idx_i,
  input logic [LANES*LANE_W-1:0]    opd0_data_o,
  input logic [1:0]                 opd1_sel_i,
  input logic [$clog2(DEPTH)-1:0]   opd1_idx_i,
  input logic [LANES*LANE_W-1:0]    opd1_data_o
);
  logic [LANES-1:0] wr_neg;
  always_comb begin
    for (int l = 0; l < LANES; l++) wr_neg[l] = bank_wdata_o[l*LANE_W + LANE_W-1];
  end

  assert_idle_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mv_valid_i |-> (!bank_rd_o && !bank_wr_o));

  assert_idle_holds_opd0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mv_valid_i |=> (!$stable(opd0_sel_i) || !$stable(opd0_idx_i) || $stable(opd0_data_o)));

  assert_bank_wr_holds_opd1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_wr_o |=> (!$stable(opd1_sel_i) || !$stable(opd1_idx_i) || $stable(opd1_data_o)));

  assert_clamped_wr_no_sign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_wr_o && mv_relu_i) |-> (wr_neg == '0));

  assert_scalar_bcast_opd0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opd0_sel_i[1] |-> (opd0_data_o == {LANES{opd0_data_o[LANE_W-1:0]}}));

  assert_scalar_bcast_opd1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opd1_sel_i[1] |-> (opd1_data_o == {LANES{opd1_data_o[LANE_W-1:0]}}));
endmodule

bind pe_operand_store pe_operand_store_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mv_valid_i   (mv_valid_i),
  .mv_relu_i    (mv_relu_i),
  .bank_rd_o    (bank_rd_o),
  .bank_wr_o    (bank_wr_o),
  .bank_wdata_o (bank_wdata_o),
  .opd0_sel_i   (opd0_sel_i),
  .opd0_idx_i   (opd0_idx_i),
  .opd0_data_o  (opd0_data_o),
  .opd1_sel_i   (opd1_sel_i),
  .opd1_idx_i   (opd1_idx_i),
  .opd1_data_o  (opd1_data_o)
);

// File: tb/pe_operand_store_test.sv
`timescale 1ns/100ps
module pe_operand_store_test;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         mv_valid_i;
  logic [1:0]   mv_src_i;
  logic [2:0]   mv_src_idx_i;
  logic [2:0]   mv_dst_i;
  logic [2:0]   mv_dst_idx_i;
  logic         mv_relu_i;
  logic [255:0] bank_rdata_i;
  logic         bank_rd_o, bank_rd_odd_o, bank_wr_o, bank_wr_odd_o;
  logic [255:0] bank_wdata_o;
  logic [1:0]   opd0_sel_i, opd1_sel_i;
  logic [2:0]   opd0_idx_i, opd1_idx_i;
  logic [255:0] opd0_data_o, opd1_data_o;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [255:0] ref_a [8];
  logic [255:0] ref_b [8];
  logic [15:0]  ref_sa [8];
  logic [15:0]  ref_sm [8];

  always #2.5 clk_i = ~clk_i;

  pe_operand_store uut (.*);

  function automatic logic [255:0] clamp(input logic [255:0] v);
    logic [255:0] r = v;
    for (int l = 0; l < 16; l++) if (v[l*16+15]) r[l*16 +: 16] = 16'h0000;
    return r;
  endfunction

  function automatic logic [255:0] opd_exp(input logic [1:0] sel, input logic [2:0] idx);
    case (sel)
      2'd0: return ref_a[idx];
      2'd1: return ref_b[idx];
      2'd2: return {16{ref_sa[idx]}};
      default: return {16{ref_sm[idx]}};
    endcase
  endfunction

  function automatic logic [255:0] rnd_vec();
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic v, input logic [1:0] src, input logic [2:0] sidx,
                     input logic [2:0] dst, input logic [2:0] didx, input logic relu,
                     input logic [255:0] rdata, input logic [1:0] s0, input logic [2:0] i0,
                     input logic [1:0] s1, input logic [2:0] i1);
    logic [255:0] sv, mv;
    logic exp_wr;
    mv_valid_i = v; mv_src_i = src; mv_src_idx_i = sidx; mv_dst_i = dst;
    mv_dst_idx_i = didx; mv_relu_i = relu; bank_rdata_i = rdata;
    opd0_sel_i = s0; opd0_idx_i = i0; opd1_sel_i = s1; opd1_idx_i = i1;
    #1;
    sv = (src == 2'd0) ? ref_a[sidx] : (src == 2'd1) ? ref_b[sidx] : rdata;
    mv = relu ? clamp(sv) : sv;
    exp_wr = v && (dst == 3'd4 || dst == 3'd5);
    chk(tag, "opd0", opd0_data_o, opd_exp(s0, i0));
    chk(tag, "opd1", opd1_data_o, opd_exp(s1, i1));
    chk(tag, "bank_rd", 256'(bank_rd_o), 256'(v && src[1]));
    chk(tag, "bank_wr", 256'(bank_wr_o), 256'(exp_wr));
    if (v && src[1]) chk(tag, "bank_rd_odd", 256'(bank_rd_odd_o), 256'(src[0]));
    if (exp_wr) begin
      chk(tag, "bank_wr_odd", 256'(bank_wr_odd_o), 256'(dst[0]));
      chk(tag, "bank_wdata", bank_wdata_o, mv);
    end
    @(posedge clk_i);
    if (v) begin
      case (dst)
        3'd0: ref_a[didx] = mv;
        3'd1: ref_b[didx] = mv;
        3'd2: ref_sa[didx] = mv[15:0];
        3'd3: ref_sm[didx] = mv[15:0];
        default: ;
      endcase
    end
    @(negedge clk_i);
  endtask

  task automatic idle(input string tag, input logic [1:0] s0, input logic [2:0] i0,
                      input logic [1:0] s1, input logic [2:0] i1);
    cyc(tag, 1'b0, 2'd2, 3'd0, 3'd0, 3'd0, 1'b0, rnd_vec(), s0, i0, s1, i1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] mixed;
    for (int i = 0; i < 8; i++) begin
      ref_a[i] = '0; ref_b[i] = '0; ref_sa[i] = '0; ref_sm[i] = '0;
    end
    rst_ni = 1'b0; mv_valid_i = 1'b1; mv_src_i = 2'd2; mv_src_idx_i = '0; mv_dst_i = 3'd0;
    mv_dst_idx_i = '0; mv_relu_i = 1'b0; bank_rdata_i = {8{32'hdeadbeef}};
    opd0_sel_i = 2'd0; opd0_idx_i = 3'd0; opd1_sel_i = 2'd3; opd1_idx_i = 3'd7;
    repeat (3) @(negedge clk_i);
    // R1: writes requested during reset are held off
    chk("R1", "opd0 in reset", opd0_data_o, '0);
    chk("R1", "opd1 in reset", opd1_data_o, '0);
    mv_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle("R1", 2'd1, 3'd5, 2'd2, 3'd3);

    // R2 / R8: fill vector A, read the target in the same cycle (old) and next cycle (new)
    for (int i = 0; i < 8; i++)
      cyc("R8", 1'b1, 2'd2, 3'd0, 3'd0, 3'(i), 1'b0, rnd_vec(), 2'd0, 3'(i), 2'd0, 3'((i + 7) % 8));
    // R2: fill vector B from the odd bank
    for (int i = 0; i < 8; i++)
      cyc("R2", 1'b1, 2'd3, 3'd0, 3'd1, 3'(i), 1'b0, rnd_vec(), 2'd1, 3'(i), 2'd0, 3'(i));
    // R3: rewrite A[3] only, B[3] must stay
    cyc("R3", 1'b1, 2'd2, 3'd0, 3'd0, 3'd3, 1'b0, {16{16'h1234}}, 2'd1, 3'd3, 2'd0, 3'd3);
    idle("R3", 2'd0, 3'd3, 2'd1, 3'd3);

    // R4 / R5: scalars take lane 0 and broadcast
    cyc("R5", 1'b1, 2'd2, 3'd0, 3'd2, 3'd2, 1'b0, {{15{16'hffff}}, 16'h3c00}, 2'd2, 3'd2, 2'd3, 3'd2);
    cyc("R5", 1'b1, 2'd3, 3'd0, 3'd3, 3'd2, 1'b0, {{15{16'h5555}}, 16'h4000}, 2'd2, 3'd2, 2'd3, 3'd2);
    idle("R4", 2'd2, 3'd2, 2'd3, 3'd2);
    cyc("R5", 1'b1, 2'd2, 3'd0, 3'd3, 3'd7, 1'b0, {{15{16'h0}}, 16'hc000}, 2'd3, 3'd7, 2'd2, 3'd7);
    idle("R4", 2'd3, 3'd7, 2'd2, 3'd7);

    // R6: clamping of sign-set lanes, including negative zero
    mixed = {4{16'h8000, 16'hffff, 16'h7fff, 16'h0000}};
    cyc("R6", 1'b1, 2'd2, 3'd0, 3'd0, 3'd6, 1'b1, mixed, 2'd0, 3'd6, 2'd1, 3'd6);
    cyc("R6", 1'b1, 2'd2, 3'd0, 3'd1, 3'd6, 1'b0, mixed, 2'd0, 3'd6, 2'd1, 3'd6);
    idle("R6", 2'd0, 3'd6, 2'd1, 3'd6);
    cyc("R6", 1'b1, 2'd3, 3'd0, 3'd2, 3'd5, 1'b1, {{15{16'h0001}}, 16'h8000}, 2'd2, 3'd5, 2'd0, 3'd6);
    idle("R6", 2'd2, 3'd5, 2'd0, 3'd6);

    // R7: write-out to banks, with and without clamp
    cyc("R7", 1'b1, 2'd1, 3'd6, 3'd4, 3'd0, 1'b1, rnd_vec(), 2'd1, 3'd6, 2'd0, 3'd0);
    cyc("R7", 1'b1, 2'd1, 3'd6, 3'd5, 3'd0, 1'b0, rnd_vec(), 2'd1, 3'd6, 2'd0, 3'd0);
    idle("R7", 2'd0, 3'd0, 2'd1, 3'd0);

    // R10: idle with busy inputs, and unused destination codes
    cyc("R10", 1'b0, 2'd0, 3'd1, 3'd1, 3'd1, 1'b1, rnd_vec(), 2'd1, 3'd1, 2'd0, 3'd1);
    cyc("R10", 1'b1, 2'd2, 3'd0, 3'd6, 3'd1, 1'b0, rnd_vec(), 2'd1, 3'd1, 2'd0, 3'd1);
    cyc("R10", 1'b1, 2'd3, 3'd0, 3'd7, 3'd1, 1'b0, rnd_vec(), 2'd1, 3'd1, 2'd0, 3'd1);
    idle("R10", 2'd1, 3'd1, 2'd0, 3'd1);

    // R11: copy A->B and B->A, then within a half
    cyc("R11", 1'b1, 2'd0, 3'd2, 3'd1, 3'd4, 1'b0, rnd_vec(), 2'd1, 3'd4, 2'd0, 3'd2);
    cyc("R11", 1'b1, 2'd1, 3'd0, 3'd0, 3'd1, 1'b1, rnd_vec(), 2'd0, 3'd1, 2'd1, 3'd0);
    cyc("R11", 1'b1, 2'd0, 3'd1, 3'd0, 3'd5, 1'b0, rnd_vec(), 2'd0, 3'd5, 2'd0, 3'd1);
    idle("R11", 2'd1, 3'd4, 2'd0, 3'd5);

    // R9: random mixed traffic on both operand ports
    for (int n = 0; n < 400; n++)
      cyc("R9", 1'($urandom), 2'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
          1'($urandom), rnd_vec(), 2'($urandom), 3'($urandom), 2'($urandom), 3'($urandom));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule